// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This controller decides which operating state a digital clock synthesizer is in. There are four states: free run (the output comes only from the calibrated local oscillator), acquiring (the loop is pulling in on a reference with its frequency slew limited), locked (the loop tracks the reference) and holdover (the output is generated from the stored frequency history). Software picks a requested mode: automatic, forced free run or forced holdover. In automatic mode the controller follows the reference-valid and no-valid-reference indications from the reference selector. It also follows the lock-detect and phase-window flags from the loop, and the history-available flag from the history unit.

The outputs are control strobes for the neighbouring blocks and a small set of status bits. The strobes are: enable tracking (the history unit accumulates), freeze to history, slew limit during acquisition, and a one-cycle phase build-out start. The loss-of-lock bit and the holdover-available bit stay set until software clears them with a read-clear strobe. The locked bit always shows the present state. A hold-good pin follows the history flag directly.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While and after reset the state is free run (mode_state 0) and every status bit, hold_good and pbo_start are 0.
- R2: When req_mode is 1 (forced free run), the next state is free run from any state. In free run, reference and lock inputs have no effect, and trk_en stays 0.
- R3: In automatic mode (req_mode 0 or 3), free run or holdover moves to acquiring (mode_state 1) one cycle after ref_valid is 1 and no_valid_ref is 0. slew_lim is 1 exactly while in acquiring.
- R4: Acquiring moves to locked (mode_state 2) only in a cycle where lock_det and phase_in_win are both 1. st_locked is 1 exactly while the state is locked.
- R5: If acquiring has lasted acq_timeout cycles (counting the entry cycle; a value of 0 acts as 1) without lock, st_lol is set. The state then moves to holdover (mode_state 3) if hist_avail is 1, and to free run otherwise.
- R6: In locked state under automatic mode with a reference present, lock_det at 0 sets st_lol and returns the state to acquiring.
- R7: In automatic mode, no_valid_ref at 1 moves locked to holdover. It moves acquiring to holdover if hist_avail is 1 and to free run if it is 0.
- R8: When req_mode is 2 (forced holdover), the next state is holdover from any state. freeze_hist is 1 exactly while in holdover.
- R9: pbo_start is a one-cycle pulse in the first cycle of every entry into acquiring, and in the cycle after ref_switch is seen in acquiring or locked state. trk_en is 1 in locked state except in a cycle where pbo_start is 1.
- R10: hold_good and st_hold_avail both rise one cycle after hist_avail rises. hold_good then follows hist_avail with one cycle of delay, while st_hold_avail stays set.
- R11: stat_rd_clr clears st_lol and st_hold_avail at the next edge. If a set condition is present in the same cycle, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_mode | input | 2 | Requested mode: 0/3 automatic, 1 forced free run, 2 forced holdover |
| ref_valid | input | 1 | Selected reference is qualified |
| no_valid_ref | input | 1 | Selector has no qualified reference at all |
| ref_switch | input | 1 | Selector switched to another reference this cycle |
| lock_det | input | 1 | Loop reports frequency lock |
| phase_in_win | input | 1 | Loop phase error is inside the lock window |
| hist_avail | input | 1 | History unit holds a usable holdover history |
| stat_rd_clr | input | 1 | Read-clear strobe for the sticky status bits |
| acq_timeout | input | TMO_W | Acquisition timeout in cycles |
| mode_state | output | 2 | 0 free run, 1 acquiring, 2 locked, 3 holdover |
| st_locked | output | 1 | Locked status, live |
| st_lol | output | 1 | Loss-of-lock status, sticky |
| st_hold_avail | output | 1 | Holdover-available status, sticky |
| hold_good | output | 1 | Hold-good pin |
| trk_en | output | 1 | Enable history tracking |
| freeze_hist | output | 1 | Freeze output frequency to history |
| slew_lim | output | 1 | Limit frequency slew during acquisition |
| pbo_start | output | 1 | Start phase build-out, one-cycle pulse |

## Verification
A wrong state register shows at once on mode_state and on the strobes decoded from it, in the very cycle after the faulty transition. That includes tracking in free run and freezing while locked. A miscounting acquisition timer shows only at the end of the window: the leave from acquiring comes a cycle early or late, and st_lol rises at that same cycle. A fault in a sticky bit stays hidden until the next read-clear, or until a set condition occurs. For that reason, clears are applied both with and without a set present.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2,
        ST_HOLD = 2'd3
    } op_state_e;

    localparam logic [1:0] REQ_FORCE_FREE = 2'd1;
    localparam logic [1:0] REQ_FORCE_HOLD = 2'd2;

    typedef struct packed {
        logic lol_evt;
        logic pbo_evt;
        logic acq_restart;
    } fsm_evt_t;

    function automatic logic req_is_auto(input logic [1:0] r);
        return (r != REQ_FORCE_FREE) && (r != REQ_FORCE_HOLD);
    endfunction

    function automatic op_state_e fallback_state(input logic hist);
        return hist ? ST_HOLD : ST_FREE;
    endfunction

endpackage

// File: rtl/dpll_acq_timer.sv
module dpll_acq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         running,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_next_ext;

    assign cnt_next_ext = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign expire = running && (cnt_next_ext >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (running && !expire) begin
            cnt_q <= cnt_next_ext[W-1:0];
        end
    end
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
    import dpll_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req_mode,
    input  logic       ref_valid,
    input  logic       no_valid_ref,
    input  logic       ref_switch,
    input  logic       lock_det,
    input  logic       phase_in_win,
    input  logic       hist_avail,
    input  logic       acq_expire,
    output op_state_e  state_q,
    output fsm_evt_t   evt,
    output logic       pbo_q
);
    op_state_e state_d;
    logic      auto_m;
    logic      ref_ok;

    assign auto_m = req_is_auto(req_mode);
    assign ref_ok = ref_valid && !no_valid_ref;

    always_comb begin
        state_d         = state_q;
        evt.lol_evt     = 1'b0;
        evt.pbo_evt     = 1'b0;
        evt.acq_restart = 1'b0;
        if (req_mode == REQ_FORCE_FREE) begin
            state_d = ST_FREE;
        end else if (req_mode == REQ_FORCE_HOLD) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    if (auto_m && ref_ok) state_d = ST_ACQ;
                end
                ST_ACQ: begin
                    if (no_valid_ref) begin
                        state_d = fallback_state(hist_avail);
                    end else if (lock_det && phase_in_win) begin
                        state_d = ST_LOCK;
                    end else if (acq_expire) begin
                        evt.lol_evt = 1'b1;
                        state_d     = fallback_state(hist_avail);
                    end else if (ref_switch) begin
                        evt.pbo_evt = 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (no_valid_ref) begin
                        state_d = ST_HOLD;
                    end else if (!lock_det) begin
                        evt.lol_evt = 1'b1;
                        state_d     = ST_ACQ;
                    end else if (ref_switch) begin
                        evt.pbo_evt = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (ref_ok) state_d = ST_ACQ;
                end
                default: state_d = ST_FREE;
            endcase
        end
        if (state_d == ST_ACQ && state_q != ST_ACQ) begin
            evt.pbo_evt = 1'b1;
        end
        evt.acq_restart = evt.pbo_evt && (state_d == ST_ACQ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            pbo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pbo_q   <= evt.pbo_evt;
        end
    end
endmodule

// File: rtl/dpll_status_regs.sv
module dpll_status_regs #(
    parameter int N_STICKY = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_STICKY-1:0] set_vec,
    input  logic                rd_clr,
    input  logic                hist_avail,
    output logic [N_STICKY-1:0] sticky_q,
    output logic                hold_good
);
    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                sticky_q[i] <= 1'b0;
            end else begin
                sticky_q[i] <= set_vec[i] | (sticky_q[i] & ~rd_clr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hold_good <= 1'b0;
        else     hold_good <= hist_avail;
    end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       req_mode,
    input  logic             ref_valid,
    input  logic             no_valid_ref,
    input  logic             ref_switch,
    input  logic             lock_det,
    input  logic             phase_in_win,
    input  logic             hist_avail,
    input  logic             stat_rd_clr,
    input  logic [TMO_W-1:0] acq_timeout,
    output logic [1:0]       mode_state,
    output logic             st_locked,
    output logic             st_lol,
    output logic             st_hold_avail,
    output logic             hold_good,
    output logic             trk_en,
    output logic             freeze_hist,
    output logic             slew_lim,
    output logic             pbo_start
);
    localparam int N_STICKY = 2;
    localparam int IDX_LOL  = 0;
    localparam int IDX_HOLD = 1;

    op_state_e             state_q;
    fsm_evt_t              evt;
    logic                  pbo_q;
    logic                  acq_expire;
    logic [N_STICKY-1:0]   sticky_set;
    logic [N_STICKY-1:0]   sticky_q;

    dpll_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_mode     (req_mode),
        .ref_valid    (ref_valid),
        .no_valid_ref (no_valid_ref),
        .ref_switch   (ref_switch),
        .lock_det     (lock_det),
        .phase_in_win (phase_in_win),
        .hist_avail   (hist_avail),
        .acq_expire   (acq_expire),
        .state_q      (state_q),
        .evt          (evt),
        .pbo_q        (pbo_q)
    );

    dpll_acq_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (evt.acq_restart),
        .running (state_q == ST_ACQ),
        .limit   (acq_timeout),
        .expire  (acq_expire)
    );

    always_comb begin
        sticky_set           = '0;
        sticky_set[IDX_LOL]  = evt.lol_evt;
        sticky_set[IDX_HOLD] = hist_avail;
    end

    dpll_status_regs #(.N_STICKY(N_STICKY)) u_status (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (sticky_set),
        .rd_clr     (stat_rd_clr),
        .hist_avail (hist_avail),
        .sticky_q   (sticky_q),
        .hold_good  (hold_good)
    );

    assign mode_state    = state_q;
    assign st_locked     = (state_q == ST_LOCK);
    assign st_lol        = sticky_q[IDX_LOL];
    assign st_hold_avail = sticky_q[IDX_HOLD];
    assign trk_en        = (state_q == ST_LOCK) && !pbo_q;
    assign freeze_hist   = (state_q == ST_HOLD);
    assign slew_lim      = (state_q == ST_ACQ);
    assign pbo_start     = pbo_q;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       req_mode,
    input logic             lock_det,
    input logic             phase_in_win,
    input logic             stat_rd_clr,
    input logic [TMO_W-1:0] acq_timeout,
    input logic [1:0]       mode_state,
    input logic             st_locked,
    input logic             st_lol,
    input logic             st_hold_avail,
    input logic             hold_good,
    input logic             trk_en,
    input logic             pbo_start
);
    logic [TMO_W:0] acq_q;
    logic [TMO_W:0] acq_cur;
    logic [TMO_W:0] acq_eff;

    assign acq_eff = (acq_timeout == '0) ? {{TMO_W{1'b0}}, 1'b1} : {1'b0, acq_timeout};
    assign acq_cur = (mode_state != 2'd1) ? '0 :
                     (pbo_start ? {{TMO_W{1'b0}}, 1'b1} : acq_q + {{TMO_W{1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst) acq_q <= '0;
        else     acq_q <= acq_cur;
    end

    // R5
    acq_window_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd1) |-> (acq_cur <= acq_eff));

    // R2
    force_free_chk: assert property (@(posedge clk) disable iff (rst)
        (req_mode == 2'd1) |=> (mode_state == 2'd0));

    // R8
    force_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_mode == 2'd2) |=> (mode_state == 2'd3));

    // R9
    pbo_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd1 && $past(mode_state) != 2'd1) |-> pbo_start);

    // R9
    track_locked_chk: assert property (@(posedge clk) disable iff (rst)
        trk_en |-> st_locked);

    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_locked) |-> $past(lock_det && phase_in_win));

    // R6
    lol_relock_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_state) == 2'd2 && mode_state == 2'd1) |-> st_lol);

    // R10
    hold_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_hold_avail) |-> hold_good);

    // R11
    lol_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_lol) |-> $past(stat_rd_clr));
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.TMO_W(TMO_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_mode      (req_mode),
    .lock_det      (lock_det),
    .phase_in_win  (phase_in_win),
    .stat_rd_clr   (stat_rd_clr),
    .acq_timeout   (acq_timeout),
    .mode_state    (mode_state),
    .st_locked     (st_locked),
    .st_lol        (st_lol),
    .st_hold_avail (st_hold_avail),
    .hold_good     (hold_good),
    .trk_en        (trk_en),
    .pbo_start     (pbo_start)
);

// File: tb/dpll_mode_ctrl_bench.sv
`timescale 1ns/1ps
module dpll_mode_ctrl_bench;
    localparam int TMO_W = 16;
    localparam logic [1:0] M_FREE = 2'd0, M_ACQ = 2'd1, M_LOCK = 2'd2, M_HOLD = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] req_mode = 2'd0;
    logic ref_valid = 1'b0, no_valid_ref = 1'b1, ref_switch = 1'b0;
    logic lock_det = 1'b0, phase_in_win = 1'b0, hist_avail = 1'b0, stat_rd_clr = 1'b0;
    logic [TMO_W-1:0] acq_timeout = 16'd5;
    logic [1:0] mode_state;
    logic st_locked, st_lol, st_hold_avail, hold_good, trk_en, freeze_hist, slew_lim, pbo_start;

    always #2 clk = ~clk;

    dpll_mode_ctrl #(.TMO_W(TMO_W)) u_dpll_mode_ctrl (
        .clk(clk), .rst(rst), .req_mode(req_mode), .ref_valid(ref_valid),
        .no_valid_ref(no_valid_ref), .ref_switch(ref_switch), .lock_det(lock_det),
        .phase_in_win(phase_in_win), .hist_avail(hist_avail), .stat_rd_clr(stat_rd_clr),
        .acq_timeout(acq_timeout), .mode_state(mode_state), .st_locked(st_locked),
        .st_lol(st_lol), .st_hold_avail(st_hold_avail), .hold_good(hold_good),
        .trk_en(trk_en), .freeze_hist(freeze_hist), .slew_lim(slew_lim), .pbo_start(pbo_start)
    );

    typedef struct {
        int         cyc;
        string      rq;
        logic [9:0] vec;
    } exp_t;

    exp_t sbq[$];
    exp_t cur_e;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // vector: mode, locked, lol, hold_avail, hold_good, pbo, trk, freeze, slew
    task automatic expect_s(input string rq, input logic [1:0] m, input logic lol,
                            input logic ha, input logic hg, input logic pbo);
        exp_t e;
        e.cyc = cyc;
        e.rq  = rq;
        e.vec = {m, (m == M_LOCK), lol, ha, hg, pbo,
                 (m == M_LOCK) && !pbo, (m == M_HOLD), (m == M_ACQ)};
        sbq.push_back(e);
    endtask

    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            logic [9:0] act;
            cur_e = sbq.pop_front();
            act = {mode_state, st_locked, st_lol, st_hold_avail, hold_good, pbo_start,
                   trk_en, freeze_hist, slew_lim};
            total++;
            if (act !== cur_e.vec) begin
                bad++;
                $display("FAIL %s cyc=%0d actual=%b expected=%b", cur_e.rq, cyc, act, cur_e.vec);
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        tick(3);
        expect_s("R1", M_FREE, 0, 0, 0, 0);
        rst = 1'b0;
        tick();
        expect_s("R1", M_FREE, 0, 0, 0, 0);
        // R2: forced free run ignores a valid reference and lock
        req_mode = 2'd1; ref_valid = 1; no_valid_ref = 0; lock_det = 1; phase_in_win = 1;
        tick(3);
        expect_s("R2", M_FREE, 0, 0, 0, 0);
        // R3: automatic with valid reference enters acquiring
        req_mode = 2'd0; lock_det = 0; phase_in_win = 0;
        tick();
        expect_s("R3", M_ACQ, 0, 0, 0, 1);
        tick();
        expect_s("R9", M_ACQ, 0, 0, 0, 0);
        tick(3);
        expect_s("R5", M_ACQ, 0, 0, 0, 0);
        tick();
        expect_s("R5", M_FREE, 1, 0, 0, 0);
        tick();
        expect_s("R3", M_ACQ, 1, 0, 0, 1);
        stat_rd_clr = 1;
        tick();
        expect_s("R11", M_ACQ, 0, 0, 0, 0);
        stat_rd_clr = 0; lock_det = 1;
        tick();
        expect_s("R4", M_ACQ, 0, 0, 0, 0);
        phase_in_win = 1;
        tick();
        expect_s("R4", M_LOCK, 0, 0, 0, 0);
        hist_avail = 1;
        tick();
        expect_s("R10", M_LOCK, 0, 1, 1, 0);
        ref_switch = 1;
        tick();
        expect_s("R9", M_LOCK, 0, 1, 1, 1);
        ref_switch = 0;
        tick();
        expect_s("R9", M_LOCK, 0, 1, 1, 0);
        hist_avail = 0;
        tick();
        expect_s("R10", M_LOCK, 0, 1, 0, 0);
        stat_rd_clr = 1;
        tick();
        expect_s("R11", M_LOCK, 0, 0, 0, 0);
        stat_rd_clr = 0; hist_avail = 1;
        tick();
        expect_s("R10", M_LOCK, 0, 1, 1, 0);
        stat_rd_clr = 1;
        tick();
        expect_s("R11", M_LOCK, 0, 1, 1, 0);
        stat_rd_clr = 0; lock_det = 0;
        tick();
        expect_s("R6", M_ACQ, 1, 1, 1, 1);
        lock_det = 1;
        tick();
        expect_s("R4", M_LOCK, 1, 1, 1, 0);
        ref_valid = 0; no_valid_ref = 1;
        tick();
        expect_s("R7", M_HOLD, 1, 1, 1, 0);
        ref_valid = 1; no_valid_ref = 0;
        tick();
        expect_s("R3", M_ACQ, 1, 1, 1, 1);
        tick();
        expect_s("R4", M_LOCK, 1, 1, 1, 0);
        req_mode = 2'd2;
        tick();
        expect_s("R8", M_HOLD, 1, 1, 1, 0);
        tick();
        expect_s("R8", M_HOLD, 1, 1, 1, 0);
        req_mode = 2'd1;
        tick();
        expect_s("R2", M_FREE, 1, 1, 1, 0);
        req_mode = 2'd0;
        tick();
        expect_s("R3", M_ACQ, 1, 1, 1, 1);
        lock_det = 0; stat_rd_clr = 1;
        tick();
        expect_s("R11", M_ACQ, 0, 1, 1, 0);
        stat_rd_clr = 0;
        tick(3);
        expect_s("R5", M_ACQ, 0, 1, 1, 0);
        tick();
        expect_s("R5", M_HOLD, 1, 1, 1, 0);
        tick();
        expect_s("R3", M_ACQ, 1, 1, 1, 1);
        hist_avail = 0; ref_valid = 0; no_valid_ref = 1;
        tick();
        expect_s("R7", M_FREE, 1, 1, 0, 0);
        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule